// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the raster timing for a TFT panel: a pixel-rate strobe, horizontal and vertical sync pulses, a data-enable flag and the coordinates of the current visible pixel. Software sets it up through a narrow write port. Every porch, sync width and active size is stored as its count minus one. The pixel strobe fires once every 2*(D+1) system clocks, where D is a divisor field.

A two-state run controller, RUN_IDLE and RUN_SCAN, gates the scan. The transition RUN_IDLE -> RUN_SCAN happens when the enable bit is seen set. RUN_SCAN -> RUN_SCAN (restart) happens at a frame end while enable is still set. RUN_SCAN -> RUN_IDLE happens at a frame end while enable is clear.

Two copies of a phase sequencer walk the four phases PH_SYNC -> PH_BACK -> PH_ACTIVE -> PH_FRONT -> PH_SYNC. One copy counts pixels within a line and the other counts lines within a frame. Every frame start latches a snapshot of the configuration registers and raises a frame interrupt. The interrupt has separate source, pending and mask bits, and a write of 1 clears the source or pending bit.

Top module: `tft_timing_gen`

## Requirements
- R1: After reset, pix_en, hsync, vsync, de, irq and irq_src are 0, pix_x and pix_y are 0, and all registers hold zero.
- R2: A register is written on a rising clock edge where wr_en is 1. The addresses are: 0 control (bit 0 enable, bits 17:8 divisor D), 1 vertical timing, 2 horizontal timing, 3 horizontal sync width (bits 7:0), 4 pending, 5 source, 6 mask (bit 1).
- R3: While scanning, pix_en is high for exactly one clock in every 2*(D+1) clocks. The first strobe comes 2*(D+1) clocks after the scan starts.
- R4: Each line spends HS+1 pixel periods in sync (hsync high), HB+1 in back porch, HA+1 active and HF+1 in front porch, in that order. The horizontal timing fields are HB at bits 25:19, HA at bits 18:8 and HF at bits 7:0, and HS is the sync width register.
- R5: Each frame spends VS+1 lines in sync (vsync high), VB+1 in back porch, VA+1 active and VF+1 in front porch, in that order. The vertical timing fields are VB at bits 31:24, VA at bits 23:14, VF at bits 13:6 and VS at bits 5:0.
- R6: de is high only when both axes are in their active phase. pix_x is the pixel index within the active part of the line and is otherwise 0. pix_y is the line index within the active lines and is otherwise 0.
- R7: If enable is 1 in the idle state, the next clock edge starts a frame at the first sync pixel of the first sync line.
- R8: Timing and divisor values are latched only at a frame start. A register write during a frame has no effect on the outputs until the next frame.
- R9: Clearing enable lets the current frame finish. After that the block idles with all timing outputs low and the coordinates at 0.
- R10: At every frame start, source bit 1 (irq_src) is set. Pending bit 1 (irq) is also set unless mask bit 1 was 1.
- R11: Writing a word with bit 1 set to the pending or source address clears that bit, and a write with bit 1 at 0 leaves it unchanged. If a frame start falls on the same edge as a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pix_en | output | 1 | One-clock pixel-rate strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Visible-area data enable |
| pix_x | output | 11 | Active pixel column |
| pix_y | output | 10 | Active line row |
| irq | output | 1 | Frame interrupt pending bit |
| irq_src | output | 1 | Frame interrupt source bit |

## Verification
Two directed geometries are tried first. One sets every field to zero, so each phase lasts one period and the divisor is 2. The other uses mixed widths and a larger divisor. These two tell apart off-by-one errors in how each phase ends and how the strobe period is counted. Random geometries then vary every field independently, which catches fields that are swapped or sliced at the wrong bit position. Each run changes the horizontal timing during a frame, clears and masks the interrupt, and then disables the block. Comparing against a reference raster computed clock by clock shows whether a change takes effect only at the frame boundary and whether the scan stops cleanly.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = 10;
    localparam int H_W    = 11;
    localparam int V_W    = 10;
    localparam int IRQ_BIT = 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_VTIM = 3'd1;
    localparam logic [ADDR_W-1:0] A_HTIM = 3'd2;
    localparam logic [ADDR_W-1:0] A_HSW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd4;
    localparam logic [ADDR_W-1:0] A_SRC  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd6;

    localparam int DIV_LSB = 8;
    localparam int VB_LSB = 24, VB_W = 8;
    localparam int VA_LSB = 14, VA_W = 10;
    localparam int VF_LSB = 6,  VF_W = 8;
    localparam int VS_LSB = 0,  VS_W = 6;
    localparam int HB_LSB = 19, HB_W = 7;
    localparam int HA_LSB = 8,  HA_W = 11;
    localparam int HF_LSB = 0,  HF_W = 8;
    localparam int HS_W   = 8;
    localparam int HTIM_W = HB_LSB + HB_W;

    typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACTIVE, PH_FRONT} phase_e;
    typedef enum logic {RUN_IDLE, RUN_SCAN} run_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [H_W-1:0]   hs, hb, ha, hf;
        logic [V_W-1:0]   vs, vb, va, vf;
    } shadow_t;
endpackage

// File: rtl/tft_tg_clkdiv.sv
module tft_tg_clkdiv
    import tft_tg_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam int CW = DW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // 2*(div+1)-1 is div shifted left with a one in the low bit
    assign limit = {div, 1'b1};
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tft_tg_axis.sv
module tft_tg_axis
    import tft_tg_pkg::*;
#(
    parameter int W = H_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_front,
    output phase_e       phase,
    output logic [W-1:0] idx,
    output logic         wrap
);
    phase_e       phase_q, phase_d;
    logic [W-1:0] cnt_q, cnt_d, len_cur;
    logic         last;

    always_comb begin
        unique case (phase_q)
            PH_SYNC:   len_cur = len_sync;
            PH_BACK:   len_cur = len_back;
            PH_ACTIVE: len_cur = len_act;
            PH_FRONT:  len_cur = len_front;
        endcase
    end

    assign last = (cnt_q == len_cur);
    assign wrap = step && last && (phase_q == PH_FRONT);

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (clear) begin
            phase_d = PH_SYNC;
            cnt_d   = '0;
        end else if (step) begin
            if (last) begin
                cnt_d = '0;
                unique case (phase_q)
                    PH_SYNC:   phase_d = PH_BACK;
                    PH_BACK:   phase_d = PH_ACTIVE;
                    PH_ACTIVE: phase_d = PH_FRONT;
                    PH_FRONT:  phase_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_SYNC;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        phase = phase_q;
        idx   = (phase_q == PH_ACTIVE) ? cnt_q : '0;
    end

    assert_hold_without_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(cnt_q) && $stable(phase_q)));
endmodule

// File: rtl/tft_tg_irq.sv
module tft_tg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic mask,
    input  logic clr_pend,
    input  logic clr_src,
    output logic pend,
    output logic src
);
    logic pend_q, src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            src_q  <= 1'b0;
        end else begin
            if (frame_start)      src_q <= 1'b1;
            else if (clr_src)     src_q <= 1'b0;
            if (frame_start && !mask) pend_q <= 1'b1;
            else if (clr_pend)        pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
    assign src  = src_q;

    assert_unmasked_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !mask) |=> pend);
    assert_source_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> src);
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tft_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic              pix_en,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [H_W-1:0]    pix_x,
    output logic [V_W-1:0]    pix_y,
    output logic              irq,
    output logic              irq_src
);
    logic              ctrl_en_q;
    logic [DIV_W-1:0]  ctrl_div_q;
    logic [REG_W-1:0]  vtim_q;
    logic [HTIM_W-1:0] htim_q;
    logic [HS_W-1:0]   hsw_q;
    logic              mask_q;

    run_e    state_q, state_d;
    shadow_t shadow_q, cfg_now;
    logic    frame_start, frame_end, axis_clear, scan;
    logic    h_wrap, v_wrap;
    phase_e  h_phase, v_phase;
    logic [H_W-1:0] h_idx;
    logic [V_W-1:0] v_idx;
    logic    clr_pend, clr_src;

    // register write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en_q  <= 1'b0;
            ctrl_div_q <= '0;
            vtim_q     <= '0;
            htim_q     <= '0;
            hsw_q      <= '0;
            mask_q     <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    ctrl_en_q  <= wr_data[0];
                    ctrl_div_q <= wr_data[DIV_LSB +: DIV_W];
                end
                A_VTIM: vtim_q <= wr_data;
                A_HTIM: htim_q <= wr_data[HTIM_W-1:0];
                A_HSW:  hsw_q  <= wr_data[HS_W-1:0];
                A_MASK: mask_q <= wr_data[IRQ_BIT];
                default: ;
            endcase
        end
    end

    assign clr_pend = wr_en && (wr_addr == A_PEND) && wr_data[IRQ_BIT];
    assign clr_src  = wr_en && (wr_addr == A_SRC)  && wr_data[IRQ_BIT];

    // unpack the live registers into the per-frame snapshot layout
    always_comb begin
        cfg_now.div = ctrl_div_q;
        cfg_now.hs  = H_W'(hsw_q);
        cfg_now.hb  = H_W'(htim_q[HB_LSB +: HB_W]);
        cfg_now.ha  = H_W'(htim_q[HA_LSB +: HA_W]);
        cfg_now.hf  = H_W'(htim_q[HF_LSB +: HF_W]);
        cfg_now.vs  = V_W'(vtim_q[VS_LSB +: VS_W]);
        cfg_now.vb  = V_W'(vtim_q[VB_LSB +: VB_W]);
        cfg_now.va  = V_W'(vtim_q[VA_LSB +: VA_W]);
        cfg_now.vf  = V_W'(vtim_q[VF_LSB +: VF_W]);
    end

    // run controller: next state
    always_comb begin
        state_d     = state_q;
        frame_start = 1'b0;
        unique case (state_q)
            RUN_IDLE: begin
                if (ctrl_en_q) begin
                    state_d     = RUN_SCAN;
                    frame_start = 1'b1;
                end
            end
            RUN_SCAN: begin
                if (frame_end) begin
                    if (ctrl_en_q) frame_start = 1'b1;
                    else           state_d     = RUN_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RUN_IDLE;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start) shadow_q <= cfg_now;
        end
    end

    assign scan       = (state_q == RUN_SCAN);
    assign frame_end  = v_wrap;
    assign axis_clear = !scan || frame_end;

    tft_tg_clkdiv #(.DW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(scan), .div(shadow_q.div), .tick(pix_en)
    );

    tft_tg_axis #(.W(H_W)) u_h (
        .clk(clk), .rst_n(rst_n), .clear(axis_clear), .step(pix_en),
        .len_sync(shadow_q.hs), .len_back(shadow_q.hb),
        .len_act(shadow_q.ha), .len_front(shadow_q.hf),
        .phase(h_phase), .idx(h_idx), .wrap(h_wrap)
    );

    tft_tg_axis #(.W(V_W)) u_v (
        .clk(clk), .rst_n(rst_n), .clear(axis_clear), .step(h_wrap),
        .len_sync(shadow_q.vs), .len_back(shadow_q.vb),
        .len_act(shadow_q.va), .len_front(shadow_q.vf),
        .phase(v_phase), .idx(v_idx), .wrap(v_wrap)
    );

    tft_tg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mask(mask_q),
        .clr_pend(clr_pend), .clr_src(clr_src), .pend(irq), .src(irq_src)
    );

    // outputs
    always_comb begin
        hsync = scan && (h_phase == PH_SYNC);
        vsync = scan && (v_phase == PH_SYNC);
        de    = scan && (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        pix_x = h_idx;
        pix_y = v_idx;
    end

    assert_de_excludes_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));
    assert_stop_at_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == RUN_SCAN) |-> $past((v_phase == PH_FRONT) && (h_phase == PH_FRONT)));
endmodule

// File: tb/tft_timing_gen_bench.sv
module tft_timing_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_en, hsync, vsync, de, irq, irq_src;
    logic [10:0] pix_x;
    logic [9:0]  pix_y;

    tft_timing_gen u_tft_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .irq(irq), .irq_src(irq_src)
    );

    int n_checks = 0;
    int n_fail = 0;
    string ctx = "R1 reset";

    // bench copy of the registers and of the per-frame snapshot
    logic [31:0] m_ctrl = '0, m_vt = '0, m_ht = '0, m_hsw = '0;
    bit m_mask = 0, m_pend = 0, m_src = 0, m_run = 0;
    int m_t = 0;
    int s_p, s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf;

    function automatic int fld(logic [31:0] r, int lo, int w);
        return int'((r >> lo) & ((32'd1 << w) - 1));
    endfunction

    function automatic void capture();
        s_p  = 2 * (fld(m_ctrl, 8, 10) + 1);
        s_hs = fld(m_hsw, 0, 8) + 1;
        s_hb = fld(m_ht, 19, 7) + 1;
        s_ha = fld(m_ht, 8, 11) + 1;
        s_hf = fld(m_ht, 0, 8) + 1;
        s_vs = fld(m_vt, 0, 6) + 1;
        s_vb = fld(m_vt, 24, 8) + 1;
        s_va = fld(m_vt, 14, 10) + 1;
        s_vf = fld(m_vt, 6, 8) + 1;
    endfunction

    function automatic int frame_len();
        return (s_hs + s_hb + s_ha + s_hf) * (s_vs + s_vb + s_va + s_vf) * s_p;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s]: actual %0d expected %0d", what, ctx, act, exp);
        end
    endtask

    task automatic check_now();
        int e_pe = 0, e_hs = 0, e_vs = 0, e_de = 0, e_x = 0, e_y = 0;
        if (m_run) begin
            int p, hp, ln;
            bit hact, vact;
            p  = m_t / s_p;
            hp = p % (s_hs + s_hb + s_ha + s_hf);
            ln = p / (s_hs + s_hb + s_ha + s_hf);
            e_pe = int'((m_t % s_p) == s_p - 1);
            e_hs = int'(hp < s_hs);
            e_vs = int'(ln < s_vs);
            hact = (hp >= s_hs + s_hb) && (hp < s_hs + s_hb + s_ha);
            vact = (ln >= s_vs + s_vb) && (ln < s_vs + s_vb + s_va);
            e_x  = hact ? hp - (s_hs + s_hb) : 0;
            e_y  = vact ? ln - (s_vs + s_vb) : 0;
            e_de = int'(hact && vact);
        end
        chk("R3 pix_en", int'(pix_en), e_pe);
        chk("R4 hsync", int'(hsync), e_hs);
        chk("R5 vsync", int'(vsync), e_vs);
        chk("R6 de", int'(de), e_de);
        chk("R6 pix_x", int'(pix_x), e_x);
        chk("R6 pix_y", int'(pix_y), e_y);
        chk("R10 irq", int'(irq), int'(m_pend));
        chk("R10 irq_src", int'(irq_src), int'(m_src));
    endtask

    // one clock: check, advance the model over the coming edge, drive a write
    task automatic step(bit w, logic [2:0] a, logic [31:0] d);
        bit fs = 0;
        @(negedge clk);
        check_now();
        if (!m_run) begin
            if (m_ctrl[0]) begin
                m_run = 1; m_t = 0; capture(); fs = 1;
            end
        end else begin
            m_t++;
            if (m_t == frame_len()) begin
                if (m_ctrl[0]) begin
                    m_t = 0; capture(); fs = 1;
                end else begin
                    m_run = 0; m_t = 0;
                end
            end
        end
        if (w && a == 3'd4 && d[1]) m_pend = 0;
        if (w && a == 3'd5 && d[1]) m_src = 0;
        if (fs) begin
            m_src = 1;
            if (!m_mask) m_pend = 1;
        end
        if (w) begin
            case (a)
                3'd0: m_ctrl = d;
                3'd1: m_vt = d;
                3'd2: m_ht = d;
                3'd3: m_hsw = d;
                3'd6: m_mask = d[1];
                default: ;
            endcase
        end
        wr_en = w; wr_addr = a; wr_data = d;
    endtask

    task automatic idle_steps(int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
    endtask

    function automatic logic [31:0] pack_h(int hb, int ha, int hf);
        return (32'(hb) << 19) | (32'(ha) << 8) | 32'(hf);
    endfunction

    function automatic logic [31:0] pack_v(int vb, int va, int vf, int vs);
        return (32'(vb) << 24) | (32'(va) << 14) | (32'(vf) << 6) | 32'(vs);
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        ctx = "R1 reset";
        check_now();
        rst_n = 1'b1;
        idle_steps(3);

        for (int k = 0; k < 6; k++) begin
            int div, hs, hb, ha, hf, vs, vb, va, vf, flen;
            logic [31:0] ctrl;
            if (k == 0) begin
                div = 0; hs = 0; hb = 0; ha = 0; hf = 0; vs = 0; vb = 0; va = 0; vf = 0;
            end else if (k == 1) begin
                div = 3; hs = 2; hb = 1; ha = 7; hf = 3; vs = 1; vb = 2; va = 4; vf = 0;
            end else begin
                div = $urandom_range(0, 2);
                hs = $urandom_range(0, 3); hb = $urandom_range(0, 3);
                ha = $urandom_range(1, 8); hf = $urandom_range(0, 3);
                vs = $urandom_range(0, 2); vb = $urandom_range(0, 2);
                va = $urandom_range(1, 5); vf = $urandom_range(0, 2);
            end
            ctrl = 32'(div) << 8;

            ctx = "R2 register programming";
            step(1'b1, 3'd1, pack_v(vb, va, vf, vs));
            step(1'b1, 3'd2, pack_h(hb, ha, hf));
            step(1'b1, 3'd3, 32'(hs));
            ctx = "R7 start from idle";
            step(1'b1, 3'd0, ctrl | 32'd1);
            flen = (hs + hb + ha + hf + 4) * (vs + vb + va + vf + 4) * 2 * (div + 1);
            idle_steps(flen + flen / 3);

            ctx = "R8 mid-frame change";
            step(1'b1, 3'd2, pack_h($urandom_range(0, 3), $urandom_range(1, 8),
                                    $urandom_range(0, 3)));
            step(1'b1, 3'd3, 32'($urandom_range(0, 3)));
            idle_steps(flen / 4);

            ctx = "R11 interrupt clear";
            step(1'b1, 3'd4, 32'h1);
            step(1'b1, 3'd4, 32'h2);
            step(1'b1, 3'd5, 32'h2);
            ctx = "R10 interrupt mask";
            step(1'b1, 3'd6, 32'($urandom_range(0, 1)) << 1);
            idle_steps(flen);

            ctx = "R9 disable";
            step(1'b1, 3'd0, ctrl);
            while (m_run) step(1'b0, 3'd0, 32'd0);
            idle_steps(20);

            ctx = "R11 cleanup";
            step(1'b1, 3'd6, 32'h0);
            step(1'b1, 3'd4, 32'h2);
            step(1'b1, 3'd5, 32'h2);
            idle_steps(3);
        end

        summary();
        $finish;
    end
endmodule